// File: doc/BRIEF.md
# Software Flow Control Matcher

This block watches the byte stream coming out of a serial receiver and compares each valid byte against programmed resume (XON) and suspend (XOFF) characters. A match on the suspend character raises `tx_hold`, which tells the transmitter to stop sending. A later match on the resume character drops `tx_hold` again. A suspend match can also raise an interrupt request.

Each character is one byte or two bytes long. A mode bit selects the length, and it applies to both characters at once. In two-byte mode the second byte must be the very next valid byte after the first. A small register bus holds these registers:

- a line control register;
- an interrupt enable register;
- a mode register;
- a read-only interrupt identification register;
- four character registers.

The four character registers can be read or written only while the line control register holds the unlock value 0xBF.

Top module: `swfc_matcher`

## Requirements
- R1: After reset, every register reads 0 (the identification register reads 0x01), `tx_hold` is 0 and `xoff_irq` is 0.
- R2: Address 3 is the line control register. It can be written and read at any time.
- R3: Addresses 4, 5, 6 and 7 hold XON first byte, XON second byte, XOFF first byte and XOFF second byte. They are written and read only while the line control register equals 0xBF. Otherwise a write leaves them unchanged and a read returns 0.
- R4: With mode bit 0 clear (one-byte mode), a valid byte equal to XOFF first byte sets `tx_hold` on the following cycle. A valid byte equal to XON first byte clears it.
- R5: With mode bit 0 set (two-byte mode), a match needs the first byte of the character followed by its second byte as the next valid byte. Idle cycles may separate the two bytes.
- R6: In two-byte mode, any other valid byte between the first and second byte cancels the partial match.
- R7: `tx_hold` keeps its value until an XON match or a reset. Repeated XOFF matches and non-matching bytes leave it set.
- R8: When one byte completes both an XON and an XOFF match, the XOFF match wins and `tx_hold` is set.
- R9: An XOFF match sets the pending interrupt only if interrupt enable bit 5 (address 0) is set. `xoff_irq` equals the pending flag ANDed with that bit.
- R10: A read of address 2 returns 0x10 while the interrupt is pending and 0x01 otherwise. The read clears the pending flag, unless an enabled XOFF match lands in the same cycle.
- R11: Address 0 (interrupt enable) and address 1 (mode) can be written and read at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears pending interrupt at address 2) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| tx_hold | output | 1 | Suspend transmission |
| xoff_irq | output | 1 | XOFF-received interrupt request |

## Verification
A corrupted stored previous byte or a lost partial match shows up as a missed or spurious two-byte match. In either case `tx_hold` is wrong one cycle after the second byte. A wrong lock decode shows up immediately as a wrong read value on a character register. A stale or spurious pending flag shows up on `xoff_irq` in the cycle after the match or the identification read. The bench compares both outputs against a behavioural model on every clock, so any such fault is caught within one cycle of the stimulus that reveals it.

// File: rtl/swfc_matcher.sv
module swfc_matcher #(
  parameter int DW = 8,
  parameter logic [DW-1:0] UNLOCK = 8'hBF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          tx_hold,
  output logic          xoff_irq
);
  localparam logic [2:0] A_IER = 3'd0, A_MODE = 3'd1, A_IIR = 3'd2, A_LCR = 3'd3;
  localparam logic [DW-1:0] IIR_NONE = DW'(8'h01);
  localparam logic [DW-1:0] IIR_XOFF = DW'(8'h10);

  logic [DW-1:0] lcr_q, ier_q, mode_q, last_q;
  logic [DW-1:0] chr_q [4];
  logic          last_vld, hold_q, pend_q;

  wire unlocked = (lcr_q == UNLOCK);
  wire two_byte = mode_q[0];
  wire irq_en   = ier_q[5];
  wire iir_rd   = reg_rd && reg_addr == A_IIR;

  wire xon_hit  = rx_valid && (two_byte
                  ? (last_vld && last_q == chr_q[0] && rx_data == chr_q[1])
                  : (rx_data == chr_q[0]));
  wire xoff_hit = rx_valid && (two_byte
                  ? (last_vld && last_q == chr_q[2] && rx_data == chr_q[3])
                  : (rx_data == chr_q[2]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      ier_q  <= '0;
      mode_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_IER:   ier_q  <= reg_wdata;
        A_MODE:  mode_q <= reg_wdata;
        A_LCR:   lcr_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_chr
    always_ff @(posedge clk) begin
      if (!rst_n)
        chr_q[i] <= '0;
      else if (reg_wr && unlocked && reg_addr == 3'(4 + i))
        chr_q[i] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q   <= '0;
      last_vld <= 1'b0;
    end else if (rx_valid) begin
      last_q   <= rx_data;
      last_vld <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        hold_q <= 1'b0;
    else if (xoff_hit) hold_q <= 1'b1;
    else if (xon_hit)  hold_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  pend_q <= 1'b0;
    else if (xoff_hit && irq_en) pend_q <= 1'b1;
    else if (iir_rd)             pend_q <= 1'b0;
  end

  always_comb begin
    case (reg_addr)
      A_IER:   reg_rdata = ier_q;
      A_MODE:  reg_rdata = mode_q;
      A_IIR:   reg_rdata = pend_q ? IIR_XOFF : IIR_NONE;
      A_LCR:   reg_rdata = lcr_q;
      default: reg_rdata = unlocked ? chr_q[reg_addr[1:0]] : '0;
    endcase
  end

  assign tx_hold  = hold_q;
  assign xoff_irq = pend_q & irq_en;

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(tx_hold));
  // R4
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_hold) |-> $past(rx_valid));
  // R3
  locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !unlocked && reg_addr[2]) |=>
      ($stable(chr_q[0]) && $stable(chr_q[1]) && $stable(chr_q[2]) && $stable(chr_q[3])));
  // R9
  pend_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(ier_q[5]));
  // R10
  iir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && !xoff_hit) |=> !pend_q);
  // R8
  xoff_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_hit |=> tx_hold);
endmodule

// File: tb/swfc_matcher_tb.sv
module swfc_matcher_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, rx_valid = 0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, rx_data = '0, reg_rdata;
  logic tx_hold, xoff_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  swfc_matcher u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_hold(tx_hold), .xoff_irq(xoff_irq));

  always #10 clk = ~clk;

  // behavioural model
  int m_lcr, m_ier, m_mode, m_pend, m_hold;
  int m_chr [4];
  int hist [$];

  function automatic bit seq_match(int c1, int c2, int b);
    if (m_mode % 2 == 0) return b == c1;
    return hist.size() > 0 && hist[$] == c1 && b == c2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lcr = 0; m_ier = 0; m_mode = 0; m_pend = 0; m_hold = 0;
      foreach (m_chr[i]) m_chr[i] = 0;
      hist.delete();
    end else begin
      bit off, on;
      int ip;
      ip  = (m_ier / 32) % 2;
      off = rx_valid && seq_match(m_chr[2], m_chr[3], rx_data);
      on  = rx_valid && seq_match(m_chr[0], m_chr[1], rx_data);
      if (reg_rd && reg_addr == 2) m_pend = 0;
      if (off && ip == 1) m_pend = 1;
      if (on) m_hold = 0;
      if (off) m_hold = 1;
      if (rx_valid) begin hist.push_back(rx_data); if (hist.size() > 2) void'(hist.pop_front()); end
      if (reg_wr) begin
        if (reg_addr == 0) m_ier = reg_wdata;
        if (reg_addr == 1) m_mode = reg_wdata;
        if (reg_addr == 3) m_lcr = reg_wdata;
        if (reg_addr >= 4 && m_lcr == 'hBF) m_chr[reg_addr - 4] = reg_wdata;
      end
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_ier;
      1: return m_mode;
      2: return m_pend ? 'h10 : 'h01;
      3: return m_lcr;
      default: return m_lcr == 'hBF ? m_chr[a - 4] : 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(tx_hold == m_hold, "R7 tx_hold", tx_hold, m_hold);
    chk(xoff_irq == (m_pend && (m_ier / 32) % 2 == 1), "R9 xoff_irq", xoff_irq,
        m_pend && (m_ier / 32) % 2 == 1);
  end

  task automatic idle();
    @(negedge clk); reg_wr = 0; reg_rd = 0; rx_valid = 0;
  endtask
  task automatic wr(int a, int d);
    @(negedge clk); reg_wr = 1; reg_rd = 0; rx_valid = 0; reg_addr = 3'(a); reg_wdata = 8'(d);
  endtask
  task automatic rd(int a, string tag);
    @(negedge clk); reg_wr = 0; reg_rd = 1; rx_valid = 0; reg_addr = 3'(a);
    #1 chk(reg_rdata == 8'(exp_rd(a)), tag, reg_rdata, exp_rd(a));
  endtask
  task automatic rx(int b);
    @(negedge clk); reg_wr = 0; reg_rd = 0; rx_valid = 1; rx_data = 8'(b);
  endtask
  task automatic expect_hold(bit e, string tag);
    idle(); @(negedge clk); chk(tx_hold == e, tag, tx_hold, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(tx_hold == 0 && xoff_irq == 0, "R1 outputs", {tx_hold, xoff_irq}, 0);
    rd(0, "R1 ier"); rd(1, "R1 mode"); rd(2, "R1 iir"); rd(3, "R1 lcr");
    wr(6, 'h13); wr(3, 'hBF); rd(6, "R3 locked write ignored"); rd(3, "R2 lcr read");
    wr(4, 'h11); wr(5, 'h22); wr(6, 'h13); wr(7, 'h33);
    for (int a = 4; a < 8; a++) rd(a, "R3 unlocked read");
    wr(3, 'h03); rd(4, "R3 locked read zero"); rd(3, "R2 lcr");
    wr(4, 'h55); wr(3, 'hBF); rd(4, "R3 write blocked");
    wr(0, 'h20); rd(0, "R11 ier"); rd(1, "R11 mode");
    // one-byte mode
    rx('h41); rx('h13); expect_hold(1, "R4 xoff one-byte");
    rd(2, "R10 iir pending"); rd(2, "R10 iir cleared");
    rx('h13); rx('h99); expect_hold(1, "R7 hold kept");
    rx('h11); expect_hold(0, "R4 xon one-byte");
    // two-byte mode
    wr(1, 1); rd(1, "R11 mode set");
    rx('h13); rx('h41); rx('h33); expect_hold(0, "R6 partial cancelled");
    rx('h13); idle(); idle(); rx('h33); expect_hold(1, "R5 two-byte xoff with gap");
    rx('h11); rx('h13); rx('h22); expect_hold(1, "R6 xon cancelled");
    rx('h13); rx('h13); rx('h33); expect_hold(1, "R5 repeated first byte");
    rx('h11); rx('h22); expect_hold(0, "R5 two-byte xon");
    // XOFF priority
    wr(1, 0); wr(4, 'h77); wr(6, 'h77); rd(2, "R10 clear before R8");
    rx('h77); expect_hold(1, "R8 xoff wins");
    // irq disabled
    wr(4, 'h11); wr(6, 'h13); rx('h11); rd(2, "R10 idle read");
    wr(0, 0); rx('h13); expect_hold(1, "R9 hold without irq");
    chk(xoff_irq == 0, "R9 irq masked", xoff_irq, 0);
    rd(2, "R9 no pending");
    // simultaneous read and match
    wr(0, 'h20);
    @(negedge clk); reg_wr = 0; reg_rd = 1; reg_addr = 3'd2; rx_valid = 1; rx_data = 8'h13;
    idle(); #1 chk(xoff_irq == 1, "R10 match beats clear", xoff_irq, 1);
    rd(2, "R10 pending after race");
    idle(); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    done = 1;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule